// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is a synthesizable model of a small synchronous burst SRAM. The data path is 36 bits wide and split into four 9-bit byte lanes. Every rising clock edge it samples three chip selects, two address strobes, a burst-advance input and the write-enable group. From these it decides whether to deselect, start a new 4-beat burst at an external address, step the burst to its next beat, or hold it on the current beat.

The two address strobes are treated differently. The processor-side strobe only counts while the primary select is active, and a burst it starts is always a read. The controller-side strobe starts a read or a write according to the write-enable group. A 2-bit beat counter forms the low address bits in either linear or interleaved order. The order is chosen by an input that is sampled when the burst starts.

Writes can cover all lanes through a global write input, or selected lanes through a byte-write gate and four lane enables. Read data comes from a register one clock after the access is accepted. An asynchronous output enable blanks both the data and its valid flag.

Top module: `sync_burst_sram`

## Requirements
- R1: With `cs_main_n` high and `astb_ctl_n` low, the edge deselects. No array lane is written, `rvalid` is low after that edge, and the active burst ends, so later advance or hold cycles make no access.
- R2: While `cs_main_n` is high, `astb_cpu_n` is ignored. With `astb_ctl_n` high, the edge decodes as an advance or hold cycle chosen by `adv_n`, and `addr` is not loaded.
- R3: With `cs_main_n` low, `astb_cpu_n` or `astb_ctl_n` low, and either `cs_hi` low or `cs_aux_n` high, the edge deselects. No write takes place, `rvalid` is low afterwards and the burst ends.
- R4: When selected (`cs_main_n`=0, `cs_hi`=1, `cs_aux_n`=0), `astb_cpu_n` low loads `addr` and starts a burst read, whatever the write enables say. No lane is written.
- R5: When selected with `astb_cpu_n` high and `astb_ctl_n` low, `addr` is loaded. The edge performs a write if the write-enable group asks for at least one lane, and a read otherwise.
- R6: With both strobes high and a burst active, the chip selects are don't-care. `adv_n` low moves to the next beat and `adv_n` high stays on the current beat. Either kind of cycle reads or writes by the write-enable group.
- R7: `wr_all_n` low writes all four lanes, whatever `wr_byte_n` and `lane_wr_n` say.
- R8: With `wr_all_n` high and `wr_byte_n` high, the cycle is a read. With `wr_byte_n` low, lane i (`wdata`/`rdata` bits [9i+8:9i]) is written when `lane_wr_n[i]` is low. If no lane enable is low, the cycle is a read.
- R9: For a burst loaded at address A, beat k (k counts advances, modulo 4) uses upper bits A[ADDR_W-1:2]. Its low bits are (A[1:0]+k) mod 4 when `order_xor` was 0 at the start, and A[1:0] XOR k when it was 1, so the fifth beat wraps to the first.
- R10: `out_en_n` high forces `rvalid` low and `rdata` to zero at once. Low shows the registered read result.
- R11: After reset, `rvalid` is low and no burst is active, so advance cycles make no access.
- R12: Read data and `rvalid`=1 appear after the clock edge that accepted a read and stay until the next edge. After an edge that accepted no read, `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_main_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_aux_n | input | 1 | Secondary chip select, active low |
| astb_cpu_n | input | 1 | Processor-side address strobe, active low |
| astb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the beat |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write gate, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| order_xor | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data, zero when blanked |
| rvalid | output | 1 | Read data valid, low when blanked |

## Verification
The bench goes after the places where the two strobes' qualification differs. A processor strobe under an inactive primary select must continue the old burst rather than reload, and a design that ignored that rule would jump to the new address. It also drives deselects with the global write asserted, which would corrupt a word if write gating did not respect deselect, and it issues advance cycles after a deselect, which would return stale data if the burst were not closed. Bursts from every starting offset in both orders are followed past the fifth beat, so a mis-wrapped counter or an order taken live instead of latched gives a wrong word. All sixteen lane-enable patterns are written and read back, so a swapped lane or an ignored global-write override shows up as a corrupted byte.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Decoded per-edge command
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_STEP  = 2'd2,
    CMD_HOLD  = 2'd3
  } cmd_e;

  // Beat counter width (4-beat bursts)
  localparam int unsigned BEAT_W = 2;

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs_main_n,
  input  logic             cs_hi,
  input  logic             cs_aux_n,
  input  logic             astb_cpu_n,
  input  logic             astb_ctl_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cmd_e             cmd,
  output logic [LANES-1:0] wmask
);

  logic             cpu_live;
  logic             any_strobe;
  logic             sel_ok;
  logic [LANES-1:0] raw_mask;

  // processor strobe only counts under an active primary select
  assign cpu_live   = ~cs_main_n & ~astb_cpu_n;
  assign any_strobe = cpu_live | ~astb_ctl_n;
  assign sel_ok     = ~cs_main_n & cs_hi & ~cs_aux_n;

  always_comb begin
    if (any_strobe) begin
      cmd = sel_ok ? CMD_LOAD : CMD_DESEL;
    end else begin
      cmd = adv_n ? CMD_HOLD : CMD_STEP;
    end
  end

  always_comb begin
    if (!wr_all_n) begin
      raw_mask = '1;
    end else if (!wr_byte_n) begin
      raw_mask = ~lane_wr_n;
    end else begin
      raw_mask = '0;
    end
  end

  // a burst opened by the processor strobe never writes
  assign wmask = (any_strobe && cpu_live) ? '0 : raw_mask;

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              order_xor,
  output logic              acc_en,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              xor_q, xor_d;
  logic              load_en;
  logic              cnt_en;
  logic [CNT_W-1:0]  lo_bits;
  logic [HI_W-1:0]   hi_bits;

  // next-state
  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    xor_d    = xor_q;
    acc_en   = 1'b0;
    load_en  = 1'b0;
    cnt_en   = 1'b0;
    unique case (cmd)
      CMD_DESEL: active_d = 1'b0;
      CMD_LOAD: begin
        active_d = 1'b1;
        base_d   = ext_addr;
        cnt_d    = '0;
        xor_d    = order_xor;
        acc_en   = 1'b1;
        load_en  = 1'b1;
        cnt_en   = 1'b1;
      end
      CMD_STEP: begin
        if (active_q) begin
          cnt_d  = cnt_q + 1'b1;
          acc_en = 1'b1;
          cnt_en = 1'b1;
        end
      end
      CMD_HOLD: acc_en = active_q;
      default: ;
    endcase
  end

  assign lo_bits  = xor_d ? (base_d[CNT_W-1:0] ^ cnt_d)
                          : (base_d[CNT_W-1:0] + cnt_d);
  assign hi_bits  = base_d[ADDR_W-1:CNT_W];
  assign acc_addr = {hi_bits, lo_bits};

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      xor_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      if (load_en) begin
        base_q <= base_d;
        xor_q  <= xor_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/sbs_lane_store.sv
module sbs_lane_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic rd_en;
  logic rvalid_q;

  assign rd_en  = acc_en & ~|wmask;
  assign rvalid = rvalid_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;
      logic              wr_en;

      assign wr_en = acc_en & wmask[g];

      always_ff @(posedge clk) begin
        if (wr_en) begin
          mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q <= '0;
        end else if (rd_en) begin
          rd_q <= mem[acc_addr];
        end
      end

      assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
    end
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_main_n,
  input  logic                    cs_hi,
  input  logic                    cs_aux_n,
  input  logic                    astb_cpu_n,
  input  logic                    astb_ctl_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    order_xor,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  cmd_e              cmd;
  logic [LANES-1:0]  wmask;
  logic              acc_en;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] st_rdata;
  logic              st_rvalid;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  sbs_cmd_decode #(.LANES(LANES)) u_decode (
    .cs_main_n (cs_main_n),
    .cs_hi     (cs_hi),
    .cs_aux_n  (cs_aux_n),
    .astb_cpu_n(astb_cpu_n),
    .astb_ctl_n(astb_ctl_n),
    .adv_n     (adv_n),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_wr_n (lane_wr_n),
    .cmd       (cmd),
    .wmask     (wmask)
  );

  sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd      (cmd),
    .ext_addr (addr),
    .order_xor(order_xor),
    .acc_en   (acc_en),
    .acc_addr (acc_addr)
  );

  sbs_lane_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc_en  (acc_en),
    .acc_addr(acc_addr),
    .wmask   (wmask),
    .wdata   (wdata),
    .rdata   (st_rdata),
    .rvalid  (st_rvalid)
  );

  // asynchronous output gating
  assign rdata  = out_en_n ? '0 : st_rdata;
  assign rvalid = st_rvalid & ~out_en_n;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_main_n,
  input logic              cs_hi,
  input logic              cs_aux_n,
  input logic              astb_cpu_n,
  input logic              astb_ctl_n,
  input logic              wr_all_n,
  input logic              wr_byte_n,
  input logic [LANES-1:0]  lane_wr_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid
);

  logic sel_ok;
  logic wants_wr;

  assign sel_ok   = ~cs_main_n & cs_hi & ~cs_aux_n;
  assign wants_wr = ~wr_all_n | (~wr_byte_n & ~(&lane_wr_n));

  // R1
  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_main_n && !astb_ctl_n) |=> !rvalid);

  // R3
  a_r3_bad_select_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_main_n && (!astb_cpu_n || !astb_ctl_n) && (!cs_hi || cs_aux_n)) |=> !rvalid);

  // R4
  a_r4_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && !astb_cpu_n) |=> (rvalid || out_en_n));

  // R5 write start
  a_r5_ctl_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && astb_cpu_n && !astb_ctl_n && wants_wr) |=> !rvalid);

  // R5 read start
  a_r5_ctl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && astb_cpu_n && !astb_ctl_n && !wants_wr) |=> (rvalid || out_en_n));

  // R10
  a_r10_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rvalid && rdata == '0));

endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES), .DATA_W(DATA_W)) u_sbs_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs_main_n (cs_main_n),
  .cs_hi     (cs_hi),
  .cs_aux_n  (cs_aux_n),
  .astb_cpu_n(astb_cpu_n),
  .astb_ctl_n(astb_ctl_n),
  .wr_all_n  (wr_all_n),
  .wr_byte_n (wr_byte_n),
  .lane_wr_n (lane_wr_n),
  .out_en_n  (out_en_n),
  .rdata     (rdata),
  .rvalid    (rvalid)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_main_n, cs_hi, cs_aux_n;
  logic              astb_cpu_n, astb_ctl_n, adv_n;
  logic              wr_all_n, wr_byte_n;
  logic [LANES-1:0]  lane_wr_n;
  logic              order_xor;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              out_en_n;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;

  logic [DATA_W-1:0] refm [DEPTH];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_aux_n(cs_aux_n),
    .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .order_xor(order_xor), .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [DATA_W-1:0] pat(input int a, input int s);
    logic [63:0] t;
    t = (64'(a + 1) * 64'h9E37_79B1) ^ (64'(s + 3) * 64'h5BD1_E995);
    return t[35:0] ^ t[63:28];
  endfunction

  task automatic idle();
    cs_main_n = 1'b1; cs_hi = 1'b0; cs_aux_n = 1'b1;
    astb_cpu_n = 1'b1; astb_ctl_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_wr_n = '1;
    order_xor = 1'b0; addr = '0; wdata = '0; out_en_n = 1'b0;
  endtask

  task automatic sel();
    cs_main_n = 1'b0; cs_hi = 1'b1; cs_aux_n = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DATA_W:0] act, input logic [DATA_W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic desel();
    idle(); astb_ctl_n = 1'b0; tick();
  endtask

  task automatic read_word(input string req, input int a);
    idle(); sel(); astb_ctl_n = 1'b0; addr = ADDR_W'(a); tick();
    chk(req, {rvalid, rdata}, {1'b1, refm[a]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset rvalid", {rvalid, rdata}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(); adv_n = 1'b0; tick();
    chk("R11 no burst after reset", {32'd0, rvalid}, '0);

    // fill the array with controller-strobe write bursts (R5, R7)
    for (int b = 0; b < DEPTH / 4; b++) begin
      idle(); sel(); astb_ctl_n = 1'b0; wr_all_n = 1'b0;
      addr = ADDR_W'(b * 4); wdata = pat(b * 4, 1); refm[b * 4] = wdata;
      tick();
      chk("R5 write start no rvalid", {32'd0, rvalid}, '0);
      for (int k = 1; k < 4; k++) begin
        idle(); adv_n = 1'b0; wr_all_n = 1'b0;
        wdata = pat(b * 4 + k, 1); refm[b * 4 + k] = wdata;
        tick();
      end
    end
    desel();

    // burst reads: both strobes, both orders, every offset, past the wrap (R4 R5 R6 R9 R12)
    for (int kind = 0; kind < 2; kind++) begin
      for (int md = 0; md < 2; md++) begin
        for (int s = 0; s < 4; s++) begin
          int b;
          b = (kind * 8 + md * 4 + s) % 16;
          idle(); sel(); order_xor = md[0]; addr = ADDR_W'(b * 4 + s);
          if (kind == 0) begin
            astb_cpu_n = 1'b0; wr_all_n = 1'b0; // R4 writes ignored
          end else begin
            astb_ctl_n = 1'b0;
          end
          tick();
          for (int k = 0; k < 5; k++) begin
            int lo;
            lo = md ? (s ^ (k & 3)) : ((s + k) & 3);
            chk(kind == 0 ? "R4 R9 R12 cpu burst" : "R5 R9 R12 ctl burst",
                {rvalid, rdata}, {1'b1, refm[b * 4 + lo]});
            if (k < 4) begin
              idle(); adv_n = 1'b0; tick(); // R6 advance, order latched
            end
          end
        end
      end
    end
    desel();

    // hold and hold-write (R6)
    idle(); sel(); astb_cpu_n = 1'b0; addr = 6'd40; tick();
    chk("R6 start", {rvalid, rdata}, {1'b1, refm[40]});
    idle(); adv_n = 1'b0; tick();
    chk("R6 advance", {rvalid, rdata}, {1'b1, refm[41]});
    idle(); tick();
    chk("R6 hold", {rvalid, rdata}, {1'b1, refm[41]});
    idle(); cs_main_n = 1'b0; tick();
    chk("R6 hold selects dont care", {rvalid, rdata}, {1'b1, refm[41]});
    idle(); adv_n = 1'b0; tick();
    chk("R6 advance after hold", {rvalid, rdata}, {1'b1, refm[42]});
    idle(); wr_all_n = 1'b0; wdata = pat(42, 7); refm[42] = wdata; tick();
    chk("R6 hold write no rvalid", {32'd0, rvalid}, '0);
    idle(); tick();
    chk("R6 hold read back", {rvalid, rdata}, {1'b1, refm[42]});
    desel();

    // processor strobe ignored under inactive primary select (R2)
    idle(); sel(); astb_cpu_n = 1'b0; addr = 6'd12; tick();
    idle(); adv_n = 1'b0; tick();
    chk("R2 setup", {rvalid, rdata}, {1'b1, refm[13]});
    idle(); astb_cpu_n = 1'b0; addr = 6'd50; adv_n = 1'b0; tick();
    chk("R2 cpu strobe ignored advance", {rvalid, rdata}, {1'b1, refm[14]});
    idle(); astb_cpu_n = 1'b0; addr = 6'd50; tick();
    chk("R2 cpu strobe ignored hold", {rvalid, rdata}, {1'b1, refm[14]});
    desel();
    idle(); astb_cpu_n = 1'b0; addr = 6'd50; tick();
    chk("R2 no start when inactive", {32'd0, rvalid}, '0);

    // lane writes over all enable patterns (R8)
    for (int m = 0; m < 16; m++) begin
      idle(); sel(); astb_ctl_n = 1'b0; wr_byte_n = 1'b0; lane_wr_n = ~4'(m);
      addr = 6'd33; wdata = pat(33, m + 10);
      tick();
      if (m == 0) chk("R8 no lane is read", {rvalid, rdata}, {1'b1, refm[33]});
      else        chk("R8 lane write no rvalid", {32'd0, rvalid}, '0);
      for (int i = 0; i < LANES; i++)
        if (m[i]) refm[33][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
      read_word("R8 lane read back", 33);
    end
    // gate high with lane enables low is a read (R8)
    idle(); sel(); astb_ctl_n = 1'b0; lane_wr_n = '0; addr = 6'd34; wdata = '1; tick();
    chk("R8 gate high reads", {rvalid, rdata}, {1'b1, refm[34]});
    read_word("R8 gate high no write", 34);
    // global write overrides (R7)
    idle(); sel(); astb_ctl_n = 1'b0; wr_all_n = 1'b0; lane_wr_n = 4'b1110;
    addr = 6'd35; wdata = pat(35, 99); refm[35] = wdata; tick();
    read_word("R7 global write gate high", 35);
    idle(); sel(); astb_ctl_n = 1'b0; wr_all_n = 1'b0; wr_byte_n = 1'b0; lane_wr_n = '1;
    addr = 6'd36; wdata = pat(36, 98); refm[36] = wdata; tick();
    read_word("R7 global write no lanes", 36);

    // deselect by primary select with write asserted (R1)
    desel();
    idle(); astb_ctl_n = 1'b0; wr_all_n = 1'b0; addr = 6'd5; wdata = ~refm[5]; tick();
    chk("R1 deselect rvalid", {32'd0, rvalid}, '0);
    idle(); adv_n = 1'b0; tick();
    chk("R1 burst ended", {32'd0, rvalid}, '0);
    read_word("R1 no write on deselect", 5);

    // secondary select deselects (R3)
    idle(); sel(); cs_hi = 1'b0; astb_cpu_n = 1'b0; addr = 6'd6; tick();
    chk("R3 cs_hi low deselect", {32'd0, rvalid}, '0);
    idle(); sel(); cs_aux_n = 1'b1; astb_ctl_n = 1'b0; wr_all_n = 1'b0;
    addr = 6'd6; wdata = ~refm[6]; tick();
    chk("R3 cs_aux high deselect", {32'd0, rvalid}, '0);
    idle(); adv_n = 1'b0; tick();
    chk("R3 burst ended", {32'd0, rvalid}, '0);
    read_word("R3 no write on deselect", 6);

    // output enable (R10)
    idle(); sel(); astb_ctl_n = 1'b0; addr = 6'd7; tick();
    out_en_n = 1'b1; #1;
    chk("R10 blanked", {rvalid, rdata}, '0);
    out_en_n = 1'b0; #1;
    chk("R10 shown", {rvalid, rdata}, {1'b1, refm[7]});
    desel();
    chk("R12 no read no rvalid", {32'd0, rvalid}, '0);

    finish_run();
  end

endmodule